// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Array

This block gives two independent requesters, called left and right, a small bank of shared ownership flags for arbitrating a common resource. Each port selects one flag by index. It requests the flag by writing a zero and gives it up by writing a one. A read tells the port whether it currently holds that flag.

Each side keeps its own request latch per flag. A request that loses, because the other side already holds the flag, stays latched. When the owner releases the flag, the token passes to the waiting side with no further write. If both sides ask for a free flag in the same clock cycle, exactly one of them is granted it. A parameter fixes which side that is.

The block is fully synchronous to one clock. A read reports the state as it stands at the start of the cycle. A write takes effect from the next cycle.

Top module: `sem_pair_array`

## Requirements
- R1: After reset every flag is free, and a selected read on either side returns all ones (8'hFF) for every index.
- R2: A selected read (sel=1) returns the addressed flag replicated on all RD_W bits: all zeros if the reading side owns that flag, all ones otherwise. A port with sel=0 reads all ones whatever it owns.
- R3: A write happens only in a cycle with both sel=1 and wr=1. It affects only the flag named by the index. A written datum of 0 is a request, and writing 0 to a free flag makes the writer its owner from the next cycle.
- R4: A flag never has two owners, so two selected reads of the same index never both return all zeros.
- R5: A request of 0 written while the other side holds the flag stays pending. When the owner writes 1, the waiting side becomes owner from the next cycle without writing again.
- R6: While one side holds a flag, a 0 written by the other side leaves ownership unchanged, and so does a repeated 0 from the owner.
- R7: When both sides write 0 to the same free flag in the same cycle, only one side is granted it: the left side when TIE_LEFT=1 (the default), otherwise the right side.
- R8: When the owner writes 1 and no request is pending on the other side, the flag becomes free and both sides read all ones.
- R9: A non-owner that writes 1 withdraws its pending request. A later release by the owner then leaves the flag free.
- R10: A read in the same cycle as a write to that flag returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe (one cycle per write) |
| l_idx | input | IDX_W (3) | Left flag index |
| l_wdat | input | 1 | Left write datum: 0 requests, 1 releases |
| l_rdat | output | RD_W (8) | Left read data: 0s when owned, 1s otherwise |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe (one cycle per write) |
| r_idx | input | IDX_W (3) | Right flag index |
| r_wdat | input | 1 | Right write datum: 0 requests, 1 releases |
| r_rdat | output | RD_W (8) | Right read data: 0s when owned, 1s otherwise |

## Verification
The flag hand-over is driven through several patterns, each aimed at a different fault:
- An uncontested grab and release separates granting from freeing.
- A contested request followed by a release checks that the losing request was really latched rather than dropped.
- A same-cycle double request on a free flag exposes a wrong or missing tie-break.
- A withdrawn request followed by a release shows whether a cancelled latch is still honoured.

Further cases separate per-flag independence from index decode errors:
- Two sides grabbing different flags at once.
- Writes strobed without select.
- Reads taken in the same cycle as a write, which show read timing.
- Reads from an unselected port.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_FREE  = 2'b00,
      OWN_LEFT  = 2'b01,
      OWN_RIGHT = 2'b10
   } owner_e;
endpackage

// File: rtl/sem_port_side.sv
// One requester side: write decode into per-flag strobes and the read mux.
module sem_port_side #(
   parameter int NUM_FLAGS = 8,
   parameter int IDX_W     = 3,
   parameter int RD_W      = 8
) (
   input  logic                 sel,
   input  logic                 wr,
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_FLAGS-1:0] own,
   output logic [NUM_FLAGS-1:0] wr_hit,
   output logic [RD_W-1:0]      rdat
);
   localparam bit FULL_MAP = ((1 << IDX_W) == NUM_FLAGS);

   logic idx_ok;
   logic own_sel;

   generate
      if (FULL_MAP) begin : g_full
         assign idx_ok = 1'b1;
      end else begin : g_part
         assign idx_ok = ({{(32-IDX_W){1'b0}}, idx} < NUM_FLAGS);
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_hit
         assign wr_hit[gi] = sel && wr && idx_ok && (idx == gi[IDX_W-1:0]);
      end
   endgenerate

   always_comb begin
      own_sel = 1'b0;
      for (int k = 0; k < NUM_FLAGS; k++) begin
         if (idx == k[IDX_W-1:0]) own_sel = own[k];
      end
   end

   assign rdat = (sel && idx_ok && own_sel) ? '0 : '1;
endmodule

// File: rtl/sem_flag_cell.sv
// One flag: two request latches plus the ownership resolver.
module sem_flag_cell
   import sem_pkg::*;
#(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_l,
   input  logic wd_l,
   input  logic wr_r,
   input  logic wd_r,
   output logic own_l,
   output logic own_r
);
   logic   req_l, req_r;
   logic   req_l_nx, req_r_nx;
   owner_e owner, owner_nx;
   owner_e tie_win;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_win = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_win = OWN_RIGHT;
      end
   endgenerate

   assign req_l_nx = wr_l ? wd_l : req_l;
   assign req_r_nx = wr_r ? wd_r : req_r;

   always_comb begin
      owner_nx = OWN_FREE;
      unique case (owner)
         OWN_LEFT: begin
            if (!req_l_nx)      owner_nx = OWN_LEFT;
            else if (!req_r_nx) owner_nx = OWN_RIGHT;
         end
         OWN_RIGHT: begin
            if (!req_r_nx)      owner_nx = OWN_RIGHT;
            else if (!req_l_nx) owner_nx = OWN_LEFT;
         end
         default: begin
            if (!req_l_nx && !req_r_nx) owner_nx = tie_win;
            else if (!req_l_nx)         owner_nx = OWN_LEFT;
            else if (!req_r_nx)         owner_nx = OWN_RIGHT;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_l <= 1'b1;
         req_r <= 1'b1;
         owner <= OWN_FREE;
      end else begin
         req_l <= req_l_nx;
         req_r <= req_r_nx;
         owner <= owner_nx;
      end
   end

   assign own_l = (owner == OWN_LEFT);
   assign own_r = (owner == OWN_RIGHT);

   AST_KEEP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_LEFT && !(wr_l && wd_l)) |=> (owner == OWN_LEFT)); // R6
   AST_KEEP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_RIGHT && !(wr_r && wd_r)) |=> (owner == OWN_RIGHT)); // R6
   AST_PASS_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_LEFT && wr_l && wd_l && !req_r && !(wr_r && wd_r)) |=> (owner == OWN_RIGHT)); // R5
   AST_PASS_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_RIGHT && wr_r && wd_r && !req_l && !(wr_l && wd_l)) |=> (owner == OWN_LEFT)); // R5
   AST_TIE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_FREE && wr_l && !wd_l && wr_r && !wd_r) |=> (owner == tie_win)); // R7
   AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_LEFT && wr_l && wd_l && req_r && !wr_r) |=> (owner == OWN_FREE)); // R8
   AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == OWN_LEFT && wr_r && wd_r && !wr_l) |=> (req_r && owner == OWN_LEFT)); // R9
endmodule

// File: rtl/sem_pair_array.sv
// Top: two requester sides sharing NUM_FLAGS ownership flags.
module sem_pair_array #(
   parameter int   NUM_FLAGS = 8,
   parameter int   RD_W      = 8,
   parameter bit   TIE_LEFT  = 1'b1,
   localparam int  IDX_W     = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_sel,
   input  logic             l_wr,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             l_wdat,
   output logic [RD_W-1:0]  l_rdat,
   input  logic             r_sel,
   input  logic             r_wr,
   input  logic [IDX_W-1:0] r_idx,
   input  logic             r_wdat,
   output logic [RD_W-1:0]  r_rdat
);
   generate
      if (NUM_FLAGS < 1) begin : g_bad_flags
         $error("sem_pair_array: NUM_FLAGS must be at least 1");
      end
      if (RD_W < 1) begin : g_bad_width
         $error("sem_pair_array: RD_W must be at least 1");
      end
      if ((1 << IDX_W) < NUM_FLAGS) begin : g_bad_idx
         $error("sem_pair_array: index width too small");
      end
   endgenerate

   logic [NUM_FLAGS-1:0] hit_l, hit_r;
   logic [NUM_FLAGS-1:0] own_l, own_r;

   sem_port_side #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .RD_W(RD_W)) u_left (
      .sel(l_sel), .wr(l_wr), .idx(l_idx), .own(own_l),
      .wr_hit(hit_l), .rdat(l_rdat)
   );

   sem_port_side #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .RD_W(RD_W)) u_right (
      .sel(r_sel), .wr(r_wr), .idx(r_idx), .own(own_r),
      .wr_hit(hit_r), .rdat(r_rdat)
   );

   genvar gf;
   generate
      for (gf = 0; gf < NUM_FLAGS; gf++) begin : g_flag
         sem_flag_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .wr_l(hit_l[gf]), .wd_l(l_wdat),
            .wr_r(hit_r[gf]), .wd_r(r_wdat),
            .own_l(own_l[gf]), .own_r(own_r[gf])
         );
      end
   endgenerate

   AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && r_sel && l_idx == r_idx) |-> !(l_rdat == '0 && r_rdat == '0)); // R4
   AST_IDLE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      !l_sel |-> (l_rdat == '1)); // R2
   AST_IDLE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !r_sel |-> (r_rdat == '1)); // R2
   AST_NOSEL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel && !r_sel && r_idx == l_idx && $past(rst_n)) |=> $stable(own_l)); // R3
endmodule

// File: tb/sim_sem_pair_array.sv
module sim_sem_pair_array;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] exp_l;
      logic [7:0] exp_r;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sel = 0, l_wr = 0, l_wdat = 1, r_sel = 0, r_wr = 0, r_wdat = 1;
   logic [2:0] l_idx = 0, r_idx = 0;
   logic [7:0] l_rdat, r_rdat;

   item_t q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sem_pair_array u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wdat(l_wdat), .l_rdat(l_rdat),
      .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_wdat(r_wdat), .r_rdat(r_rdat)
   );

   // driver: one bus cycle per call, expected reads pushed to the scoreboard
   task automatic step(input logic ls, input logic lw, input int li, input logic ld,
                       input logic rs, input logic rw, input int ri, input logic rd,
                       input logic [7:0] el, input logic [7:0] er, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      l_sel = ls; l_wr = lw; l_idx = li[2:0]; l_wdat = ld;
      r_sel = rs; r_wr = rw; r_idx = ri[2:0]; r_wdat = rd;
      it.exp_l = el; it.exp_r = er; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compares mid-cycle, away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_chk++;
         if (l_rdat !== it.exp_l) begin
            n_err++;
            $display("FAIL %s left: actual=%h expected=%h", it.tag, l_rdat, it.exp_l);
         end
         n_chk++;
         if (r_rdat !== it.exp_r) begin
            n_err++;
            $display("FAIL %s right: actual=%h expected=%h", it.tag, r_rdat, it.exp_r);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      step(1,0,0,1, 1,0,0,1, 8'hFF, 8'hFF, "R1 idx0");
      step(1,0,7,1, 1,0,7,1, 8'hFF, 8'hFF, "R1 idx7");
      // R10 read during write shows old state; R3 grab
      step(1,1,2,0, 1,0,2,1, 8'hFF, 8'hFF, "R10 same-cycle read");
      step(1,0,2,1, 1,0,2,1, 8'h00, 8'hFF, "R3 grab, R2 read");
      // R6 non-owner request, owner keeps
      step(1,0,2,1, 1,1,2,0, 8'h00, 8'hFF, "R6 contested write");
      step(1,0,2,1, 1,0,2,1, 8'h00, 8'hFF, "R6 owner kept");
      step(1,1,2,0, 1,0,2,1, 8'h00, 8'hFF, "R6 owner rewrite 0");
      // R5 hand-over to right
      step(1,1,2,1, 1,0,2,1, 8'h00, 8'hFF, "R5 release cycle");
      step(1,0,2,1, 1,0,2,1, 8'hFF, 8'h00, "R5 pass to right");
      step(1,1,2,0, 1,0,2,1, 8'hFF, 8'h00, "R6 left request queued");
      step(1,0,2,1, 1,0,2,1, 8'hFF, 8'h00, "R6 right kept");
      step(1,0,2,1, 1,1,2,1, 8'hFF, 8'h00, "R5 right release");
      step(1,0,2,1, 1,0,2,1, 8'h00, 8'hFF, "R5 pass to left");
      step(1,1,2,1, 1,0,2,1, 8'h00, 8'hFF, "R8 release");
      step(1,0,2,1, 1,0,2,1, 8'hFF, 8'hFF, "R8 free");
      // R7 tie on flag 5
      step(1,1,5,0, 1,1,5,0, 8'hFF, 8'hFF, "R7 tie cycle");
      step(1,0,5,1, 1,0,5,1, 8'h00, 8'hFF, "R7 left wins, R4");
      // R9 withdraw pending
      step(1,0,5,1, 1,1,5,1, 8'h00, 8'hFF, "R9 withdraw");
      step(1,1,5,1, 1,0,5,1, 8'h00, 8'hFF, "R9 owner release");
      step(1,0,5,1, 1,0,5,1, 8'hFF, 8'hFF, "R9 free after withdraw");
      // R3 independence across flags
      step(1,1,0,0, 1,1,1,0, 8'hFF, 8'hFF, "R3 grab different flags");
      step(1,0,0,1, 1,0,1,1, 8'h00, 8'h00, "R3 each owns its flag");
      step(1,0,1,1, 1,0,0,1, 8'hFF, 8'hFF, "R4 cross reads");
      // R2 unselected reads all ones
      step(0,0,0,1, 0,0,1,1, 8'hFF, 8'hFF, "R2 unselected");
      // R3 strobe without select is ignored
      step(0,1,3,0, 0,1,4,0, 8'hFF, 8'hFF, "R3 wr without sel");
      step(1,0,3,1, 1,0,4,1, 8'hFF, 8'hFF, "R3 no grab without sel");
      step(1,0,3,1, 1,0,3,1, 8'hFF, 8'hFF, "R3 flag3 free");
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule